// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the word address for a synchronous burst memory port. A burst begins when either of two address strobes is high at a rising clock edge. The external address is then captured and presented on the next cycle as beat 0. The upper address bits are frozen at the loaded value. The low two bits then walk through a four-beat block, and they move only in cycles where the advance input is high.

The beat order is chosen when the address is loaded. With linear order the low bits count up from the start value. With interleaved order the low bits are the start value XOR the beat index. Either way the address wraps inside its aligned four-word block.

Bursting is optional. A strobe may load a fresh address on every cycle at no cost, and a strobe always takes precedence over advance. Both outputs come straight from registers.

Top module: `burst_seq_top`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising edge), `addr_out` is 0 and `beat_idx` is 0.
- R2: If `strobe_a` or `strobe_b` (or both) is high at a rising edge, then after that edge `addr_out` equals the sampled `addr_in` and `beat_idx` is 0.
- R3: If neither strobe is high and `advance` is high at an edge, `beat_idx` increases by 1 modulo 4.
- R4: For a burst loaded with `order_lin` = 1 (linear), `addr_out[1:0]` equals (start low bits + `beat_idx`) mod 4.
- R5: For a burst loaded with `order_lin` = 0 (interleaved, the level to tie the pin to by default), `addr_out[1:0]` equals start low bits XOR `beat_idx`.
- R6: Without a strobe, `addr_out[AW-1:2]` never changes, including when the beat wraps from 3 to 0.
- R7: An edge with no strobe and no advance leaves `addr_out` and `beat_idx` unchanged.
- R8: A strobe and `advance` high in the same cycle load the new address; advance is ignored.
- R9: `order_lin` is sampled only at a load edge. Changing it during a burst does not alter the sequence of `addr_out`.
- R10: Strobes on consecutive cycles load each new address on every cycle with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_a | input | 1 | First address strobe |
| strobe_b | input | 1 | Second address strobe |
| advance | input | 1 | Step to the next beat |
| order_lin | input | 1 | 1 = linear, 0 = interleaved order, sampled at load |
| addr_in | input | AW | External start address |
| addr_out | output | AW | Current full word address (registered) |
| beat_idx | output | 2 | Beat number within the burst (registered) |

## Verification
The hardest case to reach is a burst that wraps past beat 3 while the upper bits hold, in interleaved order, with `order_lin` toggled halfway through. Reaching it takes a load followed by at least four advances, with no strobe in between. Directed sequences therefore load every start offset in both orders and advance five or more beats, flipping `order_lin` mid-burst. A long run of random strobes, advances and stalls then mixes all of this with collisions of strobe and advance.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_STEP = 2'd2
  } bsq_act_e;

  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } bsq_order_e;
endpackage

// File: rtl/bsq_load_ctl.sv
module bsq_load_ctl
  import bsq_pkg::*;
(
  input  logic     strobe_a,
  input  logic     strobe_b,
  input  logic     advance,
  output bsq_act_e act
);
  always_comb begin
    if (strobe_a || strobe_b) act = ACT_LOAD;
    else if (advance)         act = ACT_STEP;
    else                      act = ACT_HOLD;
  end
endmodule

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr
  import bsq_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  bsq_act_e      act,
  input  logic [CW-1:0] start_lo_in,
  input  logic          order_in,
  output logic [CW-1:0] beat_nxt,
  output logic [CW-1:0] beat_q,
  output logic [CW-1:0] start_lo_nxt,
  output logic [CW-1:0] start_lo_q,
  output bsq_order_e    order_nxt,
  output bsq_order_e    order_q
);
  always_comb begin
    beat_nxt     = beat_q;
    start_lo_nxt = start_lo_q;
    order_nxt    = order_q;
    case (act)
      ACT_LOAD: begin
        beat_nxt     = '0;
        start_lo_nxt = start_lo_in;
        order_nxt    = bsq_order_e'(order_in);
      end
      ACT_STEP: beat_nxt = beat_q + CW'(1);
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q     <= '0;
      start_lo_q <= '0;
      order_q    <= ORD_INTERLEAVE;
    end else begin
      beat_q     <= beat_nxt;
      start_lo_q <= start_lo_nxt;
      order_q    <= order_nxt;
    end
  end
endmodule

// File: rtl/bsq_addr_map.sv
module bsq_addr_map
  import bsq_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic [CW-1:0] start_lo,
  input  logic [CW-1:0] beat,
  input  bsq_order_e    order,
  output logic [CW-1:0] low_bits
);
  logic [CW-1:0] lin_bits;
  logic [CW-1:0] ilv_bits;

  assign lin_bits = start_lo + beat;

  genvar g;
  generate
    for (g = 0; g < CW; g++) begin : g_ilv
      assign ilv_bits[g] = start_lo[g] ^ beat[g];
    end
  endgenerate

  assign low_bits = (order == ORD_LINEAR) ? lin_bits : ilv_bits;
endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
  import bsq_pkg::*;
#(
  parameter int AW = 20,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe_a,
  input  logic          strobe_b,
  input  logic          advance,
  input  logic          order_lin,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic [CW-1:0] beat_idx
);
  localparam int HW = AW - CW;

  bsq_act_e      act;
  logic [CW-1:0] beat_nxt, beat_q, start_lo_nxt, start_lo_q, low_nxt;
  bsq_order_e    order_nxt, order_q;
  logic [HW-1:0] upper_q;

  bsq_load_ctl u_ctl (
    .strobe_a (strobe_a),
    .strobe_b (strobe_b),
    .advance  (advance),
    .act      (act)
  );

  bsq_beat_ctr #(.CW(CW)) u_ctr (
    .clk          (clk),
    .rst          (rst),
    .act          (act),
    .start_lo_in  (addr_in[CW-1:0]),
    .order_in     (order_lin),
    .beat_nxt     (beat_nxt),
    .beat_q       (beat_q),
    .start_lo_nxt (start_lo_nxt),
    .start_lo_q   (start_lo_q),
    .order_nxt    (order_nxt),
    .order_q      (order_q)
  );

  bsq_addr_map #(.CW(CW)) u_map (
    .start_lo (start_lo_nxt),
    .beat     (beat_nxt),
    .order    (order_nxt),
    .low_bits (low_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
      addr_out <= '0;
    end else begin
      if (act == ACT_LOAD) upper_q <= addr_in[AW-1:CW];
      addr_out <= {(act == ACT_LOAD) ? addr_in[AW-1:CW] : upper_q, low_nxt};
    end
  end

  assign beat_idx = beat_q;
endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
  parameter int AW = 20,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          strobe_a,
  input logic          strobe_b,
  input logic          advance,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] addr_out,
  input logic [CW-1:0] beat_idx,
  input logic [CW-1:0] start_lo_q,
  input logic          order_q
);
  logic ld;
  assign ld = strobe_a || strobe_b;

  // R1
  a_r1_reset: assert property (@(posedge clk) rst |=> (addr_out == '0 && beat_idx == '0));
  // R2, R8, R10
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    ld |=> (addr_out == $past(addr_in) && beat_idx == '0));
  // R3
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (!ld && advance) |=> beat_idx == CW'($past(beat_idx) + CW'(1)));
  // R4
  a_r4_linear: assert property (@(posedge clk) disable iff (rst)
    order_q |-> addr_out[CW-1:0] == CW'(start_lo_q + beat_idx));
  // R5
  a_r5_interleave: assert property (@(posedge clk) disable iff (rst)
    !order_q |-> addr_out[CW-1:0] == (start_lo_q ^ beat_idx));
  // R6
  a_r6_upper_hold: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(addr_out[AW-1:CW]));
  // R7
  a_r7_idle: assert property (@(posedge clk) disable iff (rst)
    (!ld && !advance) |=> ($stable(addr_out) && $stable(beat_idx)));
  // R9
  a_r9_order_kept: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(order_q));
endmodule

bind burst_seq_top bsq_checker #(.AW(AW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .strobe_a   (strobe_a),
  .strobe_b   (strobe_b),
  .advance    (advance),
  .addr_in    (addr_in),
  .addr_out   (addr_out),
  .beat_idx   (beat_idx),
  .start_lo_q (start_lo_q),
  .order_q    (order_q)
);

// File: tb/sim_burst_seq_top.sv
module sim_burst_seq_top;
  localparam int AW = 20;
  localparam int CW = 2;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, strobe_a, strobe_b, advance, order_lin;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;
  logic [CW-1:0] beat_idx;

  int n_run = 0;
  int n_fail = 0;

  int m_addr = 0, m_beat = 0, m_start = 0, m_lin = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_seq_top #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .strobe_a(strobe_a), .strobe_b(strobe_b),
    .advance(advance), .order_lin(order_lin), .addr_in(addr_in),
    .addr_out(addr_out), .beat_idx(beat_idx)
  );

  task automatic check(input string tag);
    n_run++;
    if (int'(addr_out) != m_addr || int'(beat_idx) != m_beat) begin
      n_fail++;
      $display("FAIL %s: addr=%0h beat=%0d expected addr=%0h beat=%0d",
               tag, addr_out, beat_idx, m_addr, m_beat);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input logic sa, input logic sb, input logic adv,
                     input logic lin, input int a, input string tag);
    strobe_a = sa; strobe_b = sb; advance = adv; order_lin = lin;
    addr_in = AW'(a);
    @(posedge clk);
    if (rst) begin
      m_addr = 0; m_beat = 0; m_start = 0; m_lin = 0;
    end else if (sa || sb) begin
      m_start = a; m_beat = 0; m_lin = lin; m_addr = a;
    end else if (adv) begin
      m_beat = (m_beat + 1) % 4;
      m_addr = (m_start / 4) * 4 +
               (m_lin != 0 ? ((m_start % 4) + m_beat) % 4 : ((m_start % 4) ^ m_beat));
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++; n_run++;
    $display("FAIL watchdog: expired, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    @(negedge clk);
    cyc(1, 0, 1, 1, 'h12345, "R1");
    cyc(0, 0, 0, 0, 0, "R1");
    rst = 1'b0;

    // R2/R4: linear burst via strobe_a, wrap past beat 3 (R6)
    for (int s = 0; s < 4; s++) begin
      cyc(1, 0, 0, 1, 'hABC0 + s, "R2");
      for (int k = 0; k < 6; k++) cyc(0, 0, 1, 1, 0, "R4");
    end
    // R5: interleaved via strobe_b, wrap (R6)
    for (int s = 0; s < 4; s++) begin
      cyc(0, 1, 0, 0, 'h7FFF4 + s, "R2");
      for (int k = 0; k < 6; k++) cyc(0, 0, 1, 0, 0, "R5");
    end
    // R3 / R7: stalls inside a burst
    cyc(1, 1, 0, 1, 'h00103, "R2");
    cyc(0, 0, 0, 1, 'h55555, "R7");
    cyc(0, 0, 1, 0, 0, "R3");
    cyc(0, 0, 0, 0, 0, "R7");
    cyc(0, 0, 1, 1, 0, "R3");
    cyc(0, 0, 1, 0, 0, "R6");
    // R8: strobe with advance
    cyc(1, 0, 1, 0, 'h22222, "R8");
    cyc(0, 1, 1, 1, 'h33331, "R8");
    cyc(0, 0, 1, 1, 0, "R4");
    // R9: toggle order mid-burst
    cyc(1, 0, 0, 0, 'h44442, "R9");
    for (int k = 0; k < 5; k++) cyc(0, 0, 1, k[0], 0, "R9");
    cyc(1, 0, 0, 1, 'h44441, "R9");
    for (int k = 0; k < 5; k++) cyc(0, 0, 1, ~k[0], 0, "R9");
    // R10: back-to-back loads
    for (int k = 0; k < 8; k++) cyc(k[0], ~k[0], 0, k[1], 'h10000 + k * 37, "R10");
    // mixed random
    for (int k = 0; k < 2000; k++) begin
      int r;
      r = int'($urandom);
      cyc(r[3:0] == 0, r[7:4] == 1, r[8] | r[9], r[10],
          int'($urandom) & ((1 << AW) - 1), "R3");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule